// File: doc/BRIEF.md
# Quadrature Phase Clock and Memory Write Strobe Generator

This block turns one fast clock into the timing signals of a small processor. It runs a two-bit counter that steps through a Gray sequence, so exactly one bit changes on each fast-clock edge. Four fast edges make one processor cycle. One counter bit is the processor clock. The other bit is the same waveform delayed by a quarter of a cycle, and it times memory accesses.

A write request from instruction decode is captured when the processor clock rises. It then drives the memory write-enable only in the third quarter of that cycle. At that point the processor clock is low and the quarter-delayed bit is high. Address and data change only at a processor-clock rising edge, so they are stable for a wide margin on both sides of the strobe.

A power-on hold keeps the processor in reset for its first cycles. A single-step mode holds the counter still and moves it two Gray states per step pulse, so two pulses make one processor cycle.

Top module: `gray_phase_clkgen`

## Requirements
- R1: When the counter advances, it visits the states 00, 01, 11, 10 and returns to 00, written as {bit1, bit0}. Exactly one bit changes on each advance. In free-run mode (`free_run_i`=1) it advances on every rising edge of `clk_2x_i`.
- R2: `cpu_clk_o` is bit0, which is high in states 01 and 11. `ram_clk_o` is bit1, which is high in states 11 and 10. `ram_clk_o` therefore lags `cpu_clk_o` by one quarter of a cycle.
- R3: `rst_i` is synchronous and active high. At the first edge that samples it high, the counter goes to 00, `cpu_rst_o` goes to 1 and `mem_we_o` goes to 0, whatever state the counter was in.
- R4: After `rst_i` is released, `cpu_rst_o` stays 1 for RST_CYCLES (default 2) complete processor cycles. It falls at the same edge that moves the counter from 10 to 00 at the end of the last of those cycles.
- R5: `wr_req_i` is sampled at the edge that moves the counter from 00 to 01, which is the rising edge of `cpu_clk_o`. If it was 1, `mem_we_o` is 1 only while the counter is in state 10 of that same cycle (`cpu_clk_o`=0, `ram_clk_o`=1). It is 0 in every other quarter.
- R6: A change of `wr_req_i` at any edge other than the processor-clock rising edge has no effect on `mem_we_o`.
- R7: A write request sampled while `cpu_rst_o` is 1 is discarded, and no write-enable pulse follows.
- R8: In step mode (`free_run_i`=0), the counter holds its state while no step arrives. Each 0-to-1 transition of `step_i` makes it advance exactly STEP_ADV (default 2) states, on the edges after the one that saw the transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_2x_i | input | 1 | Fast clock; one Gray state per rising edge |
| rst_i | input | 1 | Synchronous active-high power-on reset |
| free_run_i | input | 1 | 1: advance every edge; 0: single-step mode |
| step_i | input | 1 | Clean step button level, used in step mode |
| wr_req_i | input | 1 | Memory write request from instruction decode |
| cpu_clk_o | output | 1 | Processor clock (Gray bit0) |
| ram_clk_o | output | 1 | Quarter-lagged memory timing clock (Gray bit1) |
| mem_we_o | output | 1 | Gated memory write-enable, third quarter only |
| cpu_rst_o | output | 1 | Processor reset held through the first cycles |

## Verification
A corrupted Gray state shows up at the two clock pins on the very next fast edge, as a two-bit jump or a repeated phase. It also moves the write strobe out of its quarter in the same cycle. A stale write-pending flag shows up one cycle later, as a strobe in a cycle that did not request one. A miscounted power-on hold shows up at the end of the second processor cycle, when `cpu_rst_o` falls early or late. Lost step credit shows up at the clock pins after one or two fast edges, when the counter stalls or runs on.

// File: rtl/gray_clk_pkg.sv
package gray_clk_pkg;

    // Gray phases within one processor cycle, encoded {bit1, bit0}
    typedef enum logic [1:0] {
        PH_Q1 = 2'b00,
        PH_Q2 = 2'b01,
        PH_Q3 = 2'b11,
        PH_Q4 = 2'b10
    } phase_e;

    function automatic phase_e phase_next(input phase_e cur);
        phase_e nxt;
        case (cur)
            PH_Q1:   nxt = PH_Q2;
            PH_Q2:   nxt = PH_Q3;
            PH_Q3:   nxt = PH_Q4;
            default: nxt = PH_Q1;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/gray_seq.sv
module gray_seq
    import gray_clk_pkg::*;
#(
    parameter int STEP_ADV = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   free_run,
    input  logic   step_in,
    output phase_e phase_o,
    output logic   cyc_start_o,
    output logic   enter_wq_o,
    output logic   cyc_end_o
);
    localparam int CRW = $clog2(STEP_ADV + 1);

    typedef struct packed {
        phase_e         phase;
        logic [CRW-1:0] credit;
        logic           step_prev;
    } seq_t;

    seq_t s_q, s_d;
    logic adv;

    always_comb begin
        s_d = s_q;
        adv = free_run || (s_q.credit != '0);
        s_d.step_prev = step_in;
        if (adv) begin
            s_d.phase = phase_next(s_q.phase);
        end
        if (!free_run && step_in && !s_q.step_prev) begin
            s_d.credit = CRW'(STEP_ADV);
        end else if (!free_run && s_q.credit != '0) begin
            s_d.credit = s_q.credit - 1'b1;
        end else if (free_run) begin
            s_d.credit = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{phase: PH_Q1, credit: '0, step_prev: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o     = s_q.phase;
    assign cyc_start_o = adv && (s_q.phase == PH_Q1);
    assign enter_wq_o  = adv && (s_q.phase == PH_Q3);
    assign cyc_end_o   = adv && (s_q.phase == PH_Q4);

    // R1: one bit changes per advance
    p_one_bit_step_r1: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase != $past(s_q.phase)) |-> ($countones(s_q.phase ^ $past(s_q.phase)) == 1));

    // R8: no credit in step mode means the phase holds
    p_step_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!free_run && s_q.credit == '0) |=> $stable(s_q.phase));

    // R3: reset forces phase 00
    p_rst_phase_r3: assert property (@(posedge clk)
        rst |=> (s_q.phase == PH_Q1));

endmodule

// File: rtl/por_hold.sv
module por_hold #(
    parameter int RST_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_end,
    output logic cpu_rst_o
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] done;
        logic          hold;
    } por_t;

    por_t p_q, p_d;

    always_comb begin
        p_d = p_q;
        if (cyc_end && p_q.done < CW'(RST_CYCLES)) begin
            p_d.done = p_q.done + 1'b1;
        end
        p_d.hold = (p_d.done < CW'(RST_CYCLES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '{done: '0, hold: 1'b1};
        end else begin
            p_q <= p_d;
        end
    end

    assign cpu_rst_o = p_q.hold;

    // R4: the hold can only drop at a cycle boundary
    p_hold_drop_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(p_q.hold) |-> $past(cyc_end));

endmodule

// File: rtl/wr_strobe.sv
module wr_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cyc_start,
    input  logic enter_wq,
    input  logic cyc_end,
    input  logic cpu_rst,
    input  logic wr_req,
    output logic we_o
);
    typedef struct packed {
        logic pend;
        logic we;
    } wr_t;

    wr_t w_q, w_d;

    always_comb begin
        w_d = w_q;
        if (cyc_start) begin
            w_d.pend = wr_req && !cpu_rst;
        end else if (cyc_end) begin
            w_d.pend = 1'b0;
        end
        if (enter_wq) begin
            w_d.we = w_q.pend;
        end else if (cyc_end) begin
            w_d.we = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q <= '{pend: 1'b0, we: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign we_o = w_q.we;

    // R7: nothing is captured during processor reset
    p_no_capture_in_rst_r7: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && cpu_rst) |=> !w_q.pend);

endmodule

// File: rtl/gray_phase_clkgen.sv
module gray_phase_clkgen
    import gray_clk_pkg::*;
#(
    parameter int RST_CYCLES = 2,
    parameter int STEP_ADV   = 2
) (
    input  logic clk_2x_i,
    input  logic rst_i,
    input  logic free_run_i,
    input  logic step_i,
    input  logic wr_req_i,
    output logic cpu_clk_o,
    output logic ram_clk_o,
    output logic mem_we_o,
    output logic cpu_rst_o
);
    phase_e phase;
    logic   cyc_start, enter_wq, cyc_end;

    gray_seq #(.STEP_ADV(STEP_ADV)) u_seq (
        .clk         (clk_2x_i),
        .rst         (rst_i),
        .free_run    (free_run_i),
        .step_in     (step_i),
        .phase_o     (phase),
        .cyc_start_o (cyc_start),
        .enter_wq_o  (enter_wq),
        .cyc_end_o   (cyc_end)
    );

    por_hold #(.RST_CYCLES(RST_CYCLES)) u_por (
        .clk       (clk_2x_i),
        .rst       (rst_i),
        .cyc_end   (cyc_end),
        .cpu_rst_o (cpu_rst_o)
    );

    wr_strobe u_wr (
        .clk       (clk_2x_i),
        .rst       (rst_i),
        .cyc_start (cyc_start),
        .enter_wq  (enter_wq),
        .cyc_end   (cyc_end),
        .cpu_rst   (cpu_rst_o),
        .wr_req    (wr_req_i),
        .we_o      (mem_we_o)
    );

    assign cpu_clk_o = phase[0];
    assign ram_clk_o = phase[1];

    // R5: strobe only in the third quarter
    p_we_quarter_r5: assert property (@(posedge clk_2x_i) disable iff (rst_i)
        mem_we_o |-> (!cpu_clk_o && ram_clk_o));

    // R7: no strobe while the processor is held in reset
    p_we_not_in_rst_r7: assert property (@(posedge clk_2x_i) disable iff (rst_i)
        cpu_rst_o |-> !mem_we_o);

    // R3: reset drops the strobe and raises the processor reset
    p_rst_outputs_r3: assert property (@(posedge clk_2x_i)
        rst_i |=> (cpu_rst_o && !mem_we_o));

    // R4: processor reset is released entering phase 00
    p_rst_release_r4: assert property (@(posedge clk_2x_i) disable iff (rst_i)
        $fell(cpu_rst_o) |-> (!cpu_clk_o && !ram_clk_o));

endmodule

// File: tb/sim_gray_phase_clkgen.sv
module sim_gray_phase_clkgen;
    logic clk = 1'b0;
    logic rst_i = 1'b1, free_run_i = 1'b1, step_i = 1'b0, wr_req_i = 1'b0;
    logic cpu_clk_o, ram_clk_o, mem_we_o, cpu_rst_o;
    int   n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    gray_phase_clkgen u0 (
        .clk_2x_i   (clk),
        .rst_i      (rst_i),
        .free_run_i (free_run_i),
        .step_i     (step_i),
        .wr_req_i   (wr_req_i),
        .cpu_clk_o  (cpu_clk_o),
        .ram_clk_o  (ram_clk_o),
        .mem_we_o   (mem_we_o),
        .cpu_rst_o  (cpu_rst_o)
    );

    // {wr_req driven, exp cpu_clk, exp ram_clk, exp mem_we, exp cpu_rst}
    localparam logic [4:0] VEC [20] = '{
        5'b11001, 5'b11101, 5'b10101, 5'b10001,   // cycle 1 in reset
        5'b11001, 5'b01101, 5'b00101, 5'b00000,   // cycle 2, request ignored (R7)
        5'b11000, 5'b01100, 5'b00110, 5'b00000,   // write captured (R5)
        5'b01000, 5'b11100, 5'b10100, 5'b00000,   // late request ignored (R6)
        5'b11000, 5'b01100, 5'b00110, 5'b00000    // write again, pending cleared
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, got, exp, $time);
        end
    endtask

    initial begin
        #(200000 * 8);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R3: reset state
        tick(); tick();
        check("R3 cpu_clk", cpu_clk_o, 1'b0);
        check("R3 ram_clk", ram_clk_o, 1'b0);
        check("R3 mem_we", mem_we_o, 1'b0);
        check("R3 cpu_rst", cpu_rst_o, 1'b1);

        // R1 R2 R4 R5 R6 R7: free-run vector walk
        rst_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            wr_req_i = VEC[i][4];
            tick();
            check("R1/R2 cpu_clk", cpu_clk_o, VEC[i][3]);
            check("R1/R2 ram_clk", ram_clk_o, VEC[i][2]);
            check("R5 mem_we", mem_we_o, VEC[i][1]);
            check("R4 cpu_rst", cpu_rst_o, VEC[i][0]);
        end

        // R3: reset in the middle of a cycle (state 11)
        wr_req_i = 1'b1;
        tick(); tick();
        check("R3 pre cpu_clk", cpu_clk_o, 1'b1);
        check("R3 pre ram_clk", ram_clk_o, 1'b1);
        rst_i = 1'b1;
        tick();
        check("R3 mid cpu_clk", cpu_clk_o, 1'b0);
        check("R3 mid ram_clk", ram_clk_o, 1'b0);
        check("R3 mid mem_we", mem_we_o, 1'b0);
        check("R3 mid cpu_rst", cpu_rst_o, 1'b1);

        // R8: step mode
        wr_req_i = 1'b0;
        free_run_i = 1'b0;
        tick();
        rst_i = 1'b0;
        tick(); tick(); tick();
        check("R8 idle cpu_clk", cpu_clk_o, 1'b0);
        check("R8 idle ram_clk", ram_clk_o, 1'b0);
        step_i = 1'b1;
        tick();
        check("R8 A cpu_clk", cpu_clk_o, 1'b0);
        tick();
        check("R8 B cpu_clk", cpu_clk_o, 1'b1);
        check("R8 B ram_clk", ram_clk_o, 1'b0);
        tick();
        check("R8 C cpu_clk", cpu_clk_o, 1'b1);
        check("R8 C ram_clk", ram_clk_o, 1'b1);
        tick(); tick();
        check("R8 held cpu_clk", cpu_clk_o, 1'b1);
        check("R8 held ram_clk", ram_clk_o, 1'b1);
        step_i = 1'b0;
        tick();
        step_i = 1'b1;
        tick(); tick();
        check("R8 second cpu_clk", cpu_clk_o, 1'b0);
        check("R8 second ram_clk", ram_clk_o, 1'b1);
        tick();
        check("R8 wrap cpu_clk", cpu_clk_o, 1'b0);
        check("R8 wrap ram_clk", ram_clk_o, 1'b0);
        tick(); tick();
        check("R8 stop cpu_clk", cpu_clk_o, 1'b0);
        check("R8 stop ram_clk", ram_clk_o, 1'b0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule